// File: doc/BRIEF.md
# Adaptive Sample-Rate Lock Loop

This block produces the local audio sample strobe for a device that follows the average rate of an incoming sample stream. The device adjusts its own sample rate to track the sender's clock, so the sender never has to resample. A phase accumulator runs on the system clock and adds a fractional frequency word on every cycle. Each carry out of the accumulator becomes a one-cycle sample strobe. Because the fraction is kept in full, the rounding that an integer divider would drop is carried forward, and the long-term strobe rate is exactly `step/2^ACC_W` of the system clock rate.

The loop filter is a simple bang-bang rule driven by how full the receive buffer is. The fill level of the sample FIFO is compared with a target level. If the buffer is too full, the frequency word goes up by one least-significant bit so that samples are drained faster. If it is too empty, the word goes down by one. If the level is on target, the word is left alone. A correction is made at most once per update interval, which is a programmable number of strobes, and the word is held inside a programmable window. On reset the word loads a nominal value supplied on a port.

Top module: `sr_dpll`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `step_word` equals `init_step` and `sample_tick` is 0.
- R2: On every clock the accumulator adds `step_word`. `sample_tick` is high for exactly the cycle after each clock edge at which the addition carried out of bit ACC_W-1. Over a long window the strobe count is therefore `cycles*step/2^ACC_W` to within one.
- R3: An update is due once every `upd_interval` strobes, where an interval of 0 counts as 1. If fewer strobes than the interval have occurred since the last update, `step_word` does not change.
- R4: On an update with `fill_level > target_level`, `step_word` increases by one.
- R5: On an update with `fill_level < target_level`, `step_word` decreases by one. It stops at 0.
- R6: On an update with `fill_level == target_level`, `step_word` does not change.
- R7: The result of an update never exceeds `step_max`. An increase from `step_max` leaves the word at `step_max`.
- R8: The result of an update is never below `step_min`. A decrease from `step_min` leaves the word at `step_min`.
- R9: Within the window, each change of `step_word` is exactly +1 or -1.
- R10: `step_word` changes only on the second clock edge after the edge that made the interval-completing `sample_tick` visible, and it holds its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_level | input | LVL_W | Current occupancy of the sample FIFO |
| target_level | input | LVL_W | Desired FIFO occupancy |
| init_step | input | ACC_W | Nominal frequency word loaded on reset |
| step_min | input | ACC_W | Lowest frequency word an update may produce |
| step_max | input | ACC_W | Highest frequency word an update may produce |
| upd_interval | input | CNT_W | Strobes per correction (0 counts as 1) |
| sample_tick | output | 1 | One-cycle sample strobe, registered |
| step_word | output | ACC_W | Current frequency word, registered |

## Verification
`sample_tick` rises one clock edge after the carry that causes it. The strobe that completes an interval raises an internal update flag on the next edge, and `step_word` moves on the edge after that, so every correction lands two edges after its strobe becomes visible. The bench keeps a cycle-level reference model that runs on the same rising edges, pushes the expected strobe and word for each edge into a queue, and compares them on the falling edge that follows. Every output is therefore checked in exactly the cycle it is due. Directed checks on strobe counts, clamp values and held words back up the cycle-exact comparison.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  typedef enum logic [1:0] {
    NUDGE_HOLD = 2'd0,
    NUDGE_UP   = 2'd1,
    NUDGE_DOWN = 2'd2
  } nudge_t;
endpackage

// File: rtl/dpll_nco.sv
module dpll_nco #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] step,
  output logic             tick
);
  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] phase_q;
  logic [SUM_W-1:0] sum;

  always_comb sum = {1'b0, phase_q} + {1'b0, step};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      tick    <= 1'b0;
    end else begin
      phase_q <= sum[ACC_W-1:0];
      tick    <= sum[SUM_W-1];
    end
  end
endmodule

// File: rtl/dpll_upd_gate.sv
module dpll_upd_gate #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] interval,
  output logic             upd
);
  localparam int CMP_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CMP_W-1:0] eff_len;
  logic [CMP_W-1:0] cnt_inc;
  logic             last;

  always_comb begin
    eff_len = (interval == '0) ? CMP_W'(1) : {1'b0, interval};
    cnt_inc = {1'b0, cnt_q} + CMP_W'(1);
    last    = (cnt_inc >= eff_len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      upd   <= 1'b0;
    end else if (tick) begin
      if (last) begin
        cnt_q <= '0;
        upd   <= 1'b1;
      end else begin
        cnt_q <= cnt_inc[CNT_W-1:0];
        upd   <= 1'b0;
      end
    end else begin
      upd <= 1'b0;
    end
  end
endmodule

// File: rtl/dpll_step_ctl.sv
module dpll_step_ctl
  import dpll_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [LVL_W-1:0] fill,
  input  logic [LVL_W-1:0] target,
  input  logic [ACC_W-1:0] init_val,
  input  logic [ACC_W-1:0] lo,
  input  logic [ACC_W-1:0] hi,
  output logic [ACC_W-1:0] step
);
  localparam int EXT_W = ACC_W + 1;
  localparam logic [EXT_W-1:0] ALL_ONES = {1'b0, {ACC_W{1'b1}}};

  nudge_t           dir;
  logic [EXT_W-1:0] cand;
  logic [EXT_W-1:0] bounded;

  always_comb begin
    if (fill > target)      dir = NUDGE_UP;
    else if (fill < target) dir = NUDGE_DOWN;
    else                    dir = NUDGE_HOLD;
  end

  always_comb begin
    unique case (dir)
      NUDGE_UP:   cand = ({1'b0, step} == ALL_ONES) ? ALL_ONES : {1'b0, step} + EXT_W'(1);
      NUDGE_DOWN: cand = (step == '0) ? '0 : {1'b0, step} - EXT_W'(1);
      default:    cand = {1'b0, step};
    endcase
    bounded = cand;
    if (bounded < {1'b0, lo}) bounded = {1'b0, lo};
    if (bounded > {1'b0, hi}) bounded = {1'b0, hi};
  end

  always_ff @(posedge clk) begin
    if (rst)                            step <= init_val;
    else if (upd && dir != NUDGE_HOLD)  step <= bounded[ACC_W-1:0];
  end
endmodule

// File: rtl/sr_dpll.sv
module sr_dpll #(
  parameter int ACC_W = 32,
  parameter int LVL_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] fill_level,
  input  logic [LVL_W-1:0] target_level,
  input  logic [ACC_W-1:0] init_step,
  input  logic [ACC_W-1:0] step_min,
  input  logic [ACC_W-1:0] step_max,
  input  logic [CNT_W-1:0] upd_interval,
  output logic             sample_tick,
  output logic [ACC_W-1:0] step_word
);
  logic upd_due;

  dpll_nco #(.ACC_W(ACC_W)) nco_i (
    .clk (clk),
    .rst (rst),
    .step(step_word),
    .tick(sample_tick)
  );

  dpll_upd_gate #(.CNT_W(CNT_W)) gate_i (
    .clk     (clk),
    .rst     (rst),
    .tick    (sample_tick),
    .interval(upd_interval),
    .upd     (upd_due)
  );

  dpll_step_ctl #(.ACC_W(ACC_W), .LVL_W(LVL_W)) ctl_i (
    .clk     (clk),
    .rst     (rst),
    .upd     (upd_due),
    .fill    (fill_level),
    .target  (target_level),
    .init_val(init_step),
    .lo      (step_min),
    .hi      (step_max),
    .step    (step_word)
  );
endmodule

// File: rtl/sr_dpll_chk.sv
module sr_dpll_chk #(
  parameter int ACC_W = 32,
  parameter int LVL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [LVL_W-1:0] fill_level,
  input logic [LVL_W-1:0] target_level,
  input logic [ACC_W-1:0] step_min,
  input logic [ACC_W-1:0] step_max,
  input logic             sample_tick,
  input logic [ACC_W-1:0] step_word
);
  // R4: a rise needs a full buffer at the applying edge
  p_raise_full_r4: assert property (@(posedge clk) disable iff (rst)
    (step_word > $past(step_word)) && ($past(step_word) >= $past(step_min))
      |-> $past(fill_level) > $past(target_level));

  // R5: a drop needs a lean buffer at the applying edge
  p_drop_lean_r5: assert property (@(posedge clk) disable iff (rst)
    (step_word < $past(step_word)) && ($past(step_word) <= $past(step_max))
      |-> $past(fill_level) < $past(target_level));

  // R6: an on-target level never moves the word
  p_hold_on_target_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(step_word) |-> $past(fill_level) != $past(target_level));

  // R7 and R8: a new word lies inside the window that applied it
  p_window_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(step_word) && ($past(step_min) <= $past(step_max))
      |-> (step_word <= $past(step_max)) && (step_word >= $past(step_min)));

  // R9: unit steps from inside the window
  p_unit_step_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(step_word) && ($past(step_word) >= $past(step_min))
      && ($past(step_word) <= $past(step_max))
      |-> (step_word == $past(step_word) + 1) || (step_word == $past(step_word) - 1));

  // R10: a change is always preceded by a strobe two edges earlier
  p_change_after_tick_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(step_word) |-> $past(sample_tick, 2));
endmodule

bind sr_dpll sr_dpll_chk #(.ACC_W(ACC_W), .LVL_W(LVL_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .fill_level  (fill_level),
  .target_level(target_level),
  .step_min    (step_min),
  .step_max    (step_max),
  .sample_tick (sample_tick),
  .step_word   (step_word)
);

// File: tb/sr_dpll_tb_top.sv
module sr_dpll_tb_top;
  localparam int ACC_W = 32;
  localparam int LVL_W = 8;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [LVL_W-1:0] fill_level = '0;
  logic [LVL_W-1:0] target_level = '0;
  logic [ACC_W-1:0] init_step = 32'h4000_0000;
  logic [ACC_W-1:0] step_min = 32'h3000_0000;
  logic [ACC_W-1:0] step_max = 32'h5000_0000;
  logic [CNT_W-1:0] upd_interval = 8'd1;
  logic             sample_tick;
  logic [ACC_W-1:0] step_word;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #4 clk = ~clk;

  sr_dpll #(.ACC_W(ACC_W), .LVL_W(LVL_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .fill_level(fill_level), .target_level(target_level),
    .init_step(init_step), .step_min(step_min), .step_max(step_max),
    .upd_interval(upd_interval), .sample_tick(sample_tick), .step_word(step_word)
  );

  // Reference model of the requirements, one entry per rising edge
  logic [ACC_W:0] exp_q[$];
  logic [ACC_W-1:0] m_acc, m_step;
  logic m_tick, m_upd;
  int   m_cnt;

  function automatic logic [ACC_W-1:0] nudge(input logic [ACC_W-1:0] s);
    longint c;
    c = longint'(s);
    if (fill_level > target_level) c = (s == '1) ? c : c + 1;
    else if (fill_level < target_level) c = (s == '0) ? c : c - 1;
    else return s;
    if (c < longint'(step_min)) c = longint'(step_min);
    if (c > longint'(step_max)) c = longint'(step_max);
    return c[ACC_W-1:0];
  endfunction

  always @(posedge clk) begin
    logic [ACC_W:0] sum;
    logic old_tick, old_upd;
    int   eff;
    if (rst) begin
      m_acc = '0; m_step = init_step; m_tick = 1'b0; m_upd = 1'b0; m_cnt = 0;
    end else begin
      old_tick = m_tick; old_upd = m_upd;
      sum = {1'b0, m_acc} + {1'b0, m_step};
      m_acc = sum[ACC_W-1:0];
      m_tick = sum[ACC_W];
      eff = (upd_interval == 0) ? 1 : int'(upd_interval);
      m_upd = 1'b0;
      if (old_tick) begin
        if (m_cnt + 1 >= eff) begin m_cnt = 0; m_upd = 1'b1; end
        else m_cnt = m_cnt + 1;
      end
      if (old_upd) m_step = nudge(m_step);
    end
    exp_q.push_back({m_tick, m_step});
  end

  // Monitor: compare on the falling edge after each rising edge
  always @(negedge clk) begin
    logic [ACC_W:0] e;
    if (exp_q.size() > 0 && !done) begin
      e = exp_q.pop_front();
      n_checks++;
      if (sample_tick !== e[ACC_W] || step_word !== e[ACC_W-1:0]) begin
        n_errors++;
        $display("FAIL %s: tick=%0b step=%h expected tick=%0b step=%h",
                 cur_req, sample_tick, step_word, e[ACC_W], e[ACC_W-1:0]);
      end
    end
  end

  task automatic check(input string req, input logic [ACC_W-1:0] act, input logic [ACC_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    n_checks++;
    if (act < lo || act > hi) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic do_reset(input logic [ACC_W-1:0] init);
    @(negedge clk);
    rst = 1'b1; init_step = init;
    repeat (3) @(negedge clk);
    check("R1", step_word, init);
    check("R1", {31'd0, sample_tick}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", step_word, init);
    check("R1", {31'd0, sample_tick}, 32'd0);
  endtask

  task automatic count_ticks(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (sample_tick) n++;
    end
  endtask

  initial begin
    int n;
    // R1, R2, R6: nominal quarter rate, level on target
    cur_req = "R6"; fill_level = 8'd100; target_level = 8'd100; upd_interval = 8'd1;
    do_reset(32'h4000_0000);
    cur_req = "R2";
    count_ticks(400, n);
    check_range("R2", n, 99, 101);
    check("R6", step_word, 32'h4000_0000);

    // R2: fractional word 3/8, wide window
    step_min = 32'h0000_0000; step_max = 32'hFFFF_FFFF;
    do_reset(32'h6000_0000);
    count_ticks(800, n);
    check_range("R2", n, 299, 301);
    check("R6", step_word, 32'h6000_0000);

    // R4: buffer too full, one correction every 4 strobes
    step_min = 32'h3000_0000; step_max = 32'h5000_0000;
    cur_req = "R4"; upd_interval = 8'd4; fill_level = 8'd120;
    do_reset(32'h4000_0000);
    count_ticks(200, n);
    check_range("R4", int'(step_word - 32'h4000_0000), 11, 13);

    // R3: interval 0 behaves as 1
    cur_req = "R3"; upd_interval = 8'd0;
    do_reset(32'h4000_0000);
    count_ticks(200, n);
    check_range("R3", int'(step_word - 32'h4000_0000), 48, 50);

    // R3: long interval never completes, so the word holds
    upd_interval = 8'd200;
    do_reset(32'h4000_0000);
    count_ticks(300, n);
    check("R3", step_word, 32'h4000_0000);

    // R7: climbing into the ceiling
    cur_req = "R7"; upd_interval = 8'd1;
    do_reset(32'h5000_0000 - 32'd2);
    count_ticks(300, n);
    check("R7", step_word, 32'h5000_0000);

    // R5: buffer too lean, word falls
    cur_req = "R5"; fill_level = 8'd50;
    do_reset(32'h4000_0000);
    count_ticks(200, n);
    check_range("R5", int'(32'h4000_0000 - step_word), 48, 50);

    // R8: descending into the floor
    cur_req = "R8";
    do_reset(32'h3000_0000 + 32'd2);
    count_ticks(300, n);
    check("R8", step_word, 32'h3000_0000);

    // R9, R10: mixed levels, cycle-exact via the scoreboard
    cur_req = "R9";
    do_reset(32'h4000_0000);
    for (int k = 0; k < 12; k++) begin
      fill_level = (k % 3 == 0) ? 8'd130 : ((k % 3 == 1) ? 8'd70 : 8'd100);
      upd_interval = 8'(k % 4);
      cur_req = (k % 2 == 0) ? "R9" : "R10";
      count_ticks(60, n);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule